// File: doc/BRIEF.md
# Far Transfer Privilege Checker

This block decides whether a far call or far jump may proceed under a four-ring protection model. Ring 0 is the most privileged and ring 3 the least. Each request carries the following:

- the privilege field of the requestor's selector;
- whether entry is direct to a code segment or goes through a call gate;
- whether the operation is a call or a jump;
- the gate's own privilege level;
- the target code segment's privilege level and its conforming flag.

The block holds the current privilege level in an internal register. It answers each request with four things: a general protection fault flag, a stack-switch flag, the privilege level that execution continues at, and the register's updated value. On an accepted transfer the register takes the new level. On a fault it keeps its value.

A small state machine with three states orders the work:

- `ST_IDLE`: the block is ready. It moves to `ST_EVAL` when `in_valid` is seen, and the request fields are captured on that edge.
- `ST_EVAL`: the block applies the rule set to the captured request and the current level. It moves unconditionally to `ST_RESP`. On that edge it registers the verdict and loads the privilege register when there is no fault.
- `ST_RESP`: the block presents the verdict. It returns to `ST_IDLE` when `out_ready` is high.

Two rule units run side by side, one for direct entry and one for gate entry. The gate flag of the captured request picks which verdict is used.

Top module: `farxfer_guard`

## Requirements
- R1: After reset, `cur_pl` equals parameter `RESET_PL` (default 0), `in_ready` is 1 and `out_valid` is 0.
- R2: A request is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the response is consumed. `out_valid` rises two edges after acceptance. While `out_ready` is 0, `out_valid`, `out_fault`, `out_stack_switch` and `out_new_pl` hold their values, and any `in_valid` is ignored.
- R3: A direct entry (`in_gate`=0) to a non-conforming target (`in_tgt_conf`=0) is allowed only when `in_rpl` <= current level and `in_tgt_dpl` equals the current level. Any other case faults.
- R4: A direct entry to a conforming target (`in_tgt_conf`=1) is allowed exactly when `in_tgt_dpl` <= current level. A more privileged conforming target is permitted and runs at the caller's level.
- R5: A direct entry never reports a stack switch, and it reports `out_new_pl` equal to the current level. `in_gate_dpl` has no effect on a direct entry.
- R6: A gate entry (`in_gate`=1) faults when max(current level, `in_rpl`) > `in_gate_dpl`. It also faults when `in_tgt_dpl` > current level. A gate at level 3 therefore admits every caller.
- R7: A gate call (`in_call`=1) that passes R6 and targets a non-conforming segment with `in_tgt_dpl` < current level reports `out_stack_switch`=1 and `out_new_pl`=`in_tgt_dpl`.
- R8: A gate call that passes R6, in any case other than the one in R7, reports no stack switch and `out_new_pl` equal to the current level.
- R9: A gate jump (`in_call`=0) that passes R6 faults when the target is non-conforming and `in_tgt_dpl` < current level. Otherwise it reports no stack switch and `out_new_pl` equal to the current level.
- R10: When `out_valid` is 1, `cur_pl` already holds the new level: it equals `out_new_pl` after an accepted transfer, and it is unchanged after a fault.
- R11: A faulting request reports `out_stack_switch`=0 and `out_new_pl` equal to the current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_gate | input | 1 | 1 = entry through a call gate, 0 = direct |
| in_call | input | 1 | 1 = call, 0 = jump |
| in_rpl | input | 2 | Requestor selector privilege field |
| in_tgt_dpl | input | 2 | Target code segment privilege level |
| in_tgt_conf | input | 1 | 1 = target is conforming |
| in_gate_dpl | input | 2 | Gate privilege level (gate entry only) |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_fault | output | 1 | General protection fault |
| out_stack_switch | output | 1 | Stack switch required |
| out_new_pl | output | 2 | Privilege level after the transfer |
| cur_pl | output | 2 | Current privilege register |

## Verification
The bench builds the block with `RESET_PL` = 3 instead of the default 0. Because the privilege register can only move toward ring 0 through a gate call, starting at ring 3 makes every current level reachable through the normal interface: a gate call to a non-conforming target at level c brings the register to c. After each reset and this setup, the bench sweeps every combination of entry kind, call or jump, conforming flag, requestor field, target level and gate level against each of the four current levels, and it exercises back-pressure on the response side separately.

// File: rtl/farxfer_pkg.sv
package farxfer_pkg;

    localparam int unsigned PL_W = 2;

    typedef logic [PL_W-1:0] pl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_RESP = 2'd2
    } fsm_e;

    typedef struct packed {
        logic via_gate;
        logic is_call;
        pl_t  rpl;
        pl_t  tgt_dpl;
        logic tgt_conf;
        pl_t  gate_dpl;
    } xfer_req_t;

    typedef struct packed {
        logic fault;
        logic stack_sw;
        pl_t  new_pl;
    } verdict_t;

    function automatic pl_t pl_weaker(input pl_t a, input pl_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/farxfer_direct_rule.sv
module farxfer_direct_rule
    import farxfer_pkg::*;
(
    input  pl_t      cur,
    input  pl_t      rpl,
    input  pl_t      tgt_dpl,
    input  logic     tgt_conf,
    output verdict_t verdict
);
    logic allowed;

    always_comb begin
        if (tgt_conf) begin
            allowed = (tgt_dpl <= cur);
        end else begin
            allowed = (rpl <= cur) && (tgt_dpl == cur);
        end
        verdict.fault    = !allowed;
        verdict.stack_sw = 1'b0;
        verdict.new_pl   = cur;
    end

endmodule

// File: rtl/farxfer_gate_rule.sv
module farxfer_gate_rule
    import farxfer_pkg::*;
(
    input  pl_t      cur,
    input  pl_t      rpl,
    input  pl_t      gate_dpl,
    input  pl_t      tgt_dpl,
    input  logic     tgt_conf,
    input  logic     is_call,
    output verdict_t verdict
);
    pl_t  eff_rpl;
    logic gate_open;
    logic tgt_reachable;
    logic inward;

    always_comb begin
        eff_rpl       = pl_weaker(cur, rpl);
        gate_open     = (eff_rpl <= gate_dpl);
        tgt_reachable = (tgt_dpl <= cur);
        inward        = !tgt_conf && (tgt_dpl < cur);

        verdict.fault    = 1'b0;
        verdict.stack_sw = 1'b0;
        verdict.new_pl   = cur;

        if (!gate_open || !tgt_reachable) begin
            verdict.fault = 1'b1;
        end else if (inward) begin
            if (is_call) begin
                verdict.stack_sw = 1'b1;
                verdict.new_pl   = tgt_dpl;
            end else begin
                verdict.fault = 1'b1;
            end
        end
    end

endmodule

// File: rtl/farxfer_pl_reg.sv
module farxfer_pl_reg
    import farxfer_pkg::*;
#(
    parameter pl_t INIT_PL = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  pl_t  d,
    output pl_t  q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT_PL;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/farxfer_guard.sv
module farxfer_guard
    import farxfer_pkg::*;
#(
    parameter logic [PL_W-1:0] RESET_PL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_gate,
    input  logic            in_call,
    input  logic [PL_W-1:0] in_rpl,
    input  logic [PL_W-1:0] in_tgt_dpl,
    input  logic            in_tgt_conf,
    input  logic [PL_W-1:0] in_gate_dpl,
    output logic            out_valid,
    input  logic            out_ready,
    output logic            out_fault,
    output logic            out_stack_switch,
    output logic [PL_W-1:0] out_new_pl,
    output logic [PL_W-1:0] cur_pl
);
    fsm_e      state_q, state_d;
    xfer_req_t req_q;
    verdict_t  direct_v, gate_v, chosen_v, res_q;
    logic      accept;
    logic      pl_load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_RESP;
            ST_RESP: if (out_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_RESP);
        accept    = in_ready && in_valid;
        pl_load   = (state_q == ST_EVAL) && !chosen_v.fault;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.via_gate <= in_gate;
            req_q.is_call  <= in_call;
            req_q.rpl      <= in_rpl;
            req_q.tgt_dpl  <= in_tgt_dpl;
            req_q.tgt_conf <= in_tgt_conf;
            req_q.gate_dpl <= in_gate_dpl;
        end
    end

    farxfer_direct_rule u_direct (
        .cur      (cur_pl),
        .rpl      (req_q.rpl),
        .tgt_dpl  (req_q.tgt_dpl),
        .tgt_conf (req_q.tgt_conf),
        .verdict  (direct_v)
    );

    farxfer_gate_rule u_gate (
        .cur      (cur_pl),
        .rpl      (req_q.rpl),
        .gate_dpl (req_q.gate_dpl),
        .tgt_dpl  (req_q.tgt_dpl),
        .tgt_conf (req_q.tgt_conf),
        .is_call  (req_q.is_call),
        .verdict  (gate_v)
    );

    assign chosen_v = req_q.via_gate ? gate_v : direct_v;

    // verdict register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (state_q == ST_EVAL) begin
            res_q <= chosen_v;
        end
    end

    farxfer_pl_reg #(.INIT_PL(RESET_PL)) u_pl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pl_load),
        .d     (chosen_v.new_pl),
        .q     (cur_pl)
    );

    assign out_fault        = res_q.fault;
    assign out_stack_switch = res_q.stack_sw;
    assign out_new_pl       = res_q.new_pl;

    // R2
    hold_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_fault)
            && $stable(out_stack_switch) && $stable(out_new_pl));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    // R10
    pl_matches_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cur_pl == out_new_pl);

    // R11
    fault_no_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fault |-> !out_stack_switch);

    // R7
    switch_goes_inward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && out_stack_switch |-> out_new_pl < $past(cur_pl));

    // R5
    direct_keeps_pl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EVAL && !req_q.via_gate |=> cur_pl == $past(cur_pl));

endmodule

// File: tb/farxfer_guard_test.sv
`timescale 1ns/1ps
module farxfer_guard_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_gate = 1'b0;
    logic       in_call = 1'b0;
    logic [1:0] in_rpl = '0;
    logic [1:0] in_tgt_dpl = '0;
    logic       in_tgt_conf = 1'b0;
    logic [1:0] in_gate_dpl = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       out_fault;
    logic       out_stack_switch;
    logic [1:0] out_new_pl;
    logic [1:0] cur_pl;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    farxfer_guard #(.RESET_PL(2'd3)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_gate(in_gate), .in_call(in_call), .in_rpl(in_rpl),
        .in_tgt_dpl(in_tgt_dpl), .in_tgt_conf(in_tgt_conf), .in_gate_dpl(in_gate_dpl),
        .out_valid(out_valid), .out_ready(out_ready), .out_fault(out_fault),
        .out_stack_switch(out_stack_switch), .out_new_pl(out_new_pl), .cur_pl(cur_pl)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_xfer(input int g, input int c, input int r, input int t,
                           input int cf, input int gd,
                           output int f, output int ss, output int np, output int cp);
        @(negedge clk);
        in_valid = 1'b1;
        in_gate = g[0];
        in_call = c[0];
        in_rpl = r[1:0];
        in_tgt_dpl = t[1:0];
        in_tgt_conf = cf[0];
        in_gate_dpl = gd[1:0];
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R2 busy", int'(in_ready), 0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, "R2 valid", int'(out_valid), 1);
        f = int'(out_fault);
        ss = int'(out_stack_switch);
        np = int'(out_new_pl);
        cp = int'(cur_pl);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    function automatic void model(input int cur, input int g, input int c, input int r,
                                  input int t, input int cf, input int gd,
                                  output int f, output int ss, output int np);
        int eff;
        f = 0; ss = 0; np = cur;
        if (g == 0) begin
            if (cf == 1) f = (t > cur) ? 1 : 0;
            else f = (r > cur || t != cur) ? 1 : 0;
        end else begin
            eff = (r > cur) ? r : cur;
            if (eff > gd || t > cur) f = 1;
            else if (cf == 0 && t < cur) begin
                if (c == 1) begin ss = 1; np = t; end
                else f = 1;
            end
        end
    endfunction

    function automatic string rule_tag(input int cur, input int g, input int c, input int r,
                                       input int t, input int cf, input int gd);
        int eff;
        eff = (r > cur) ? r : cur;
        if (g == 0) return (cf == 1) ? "R4" : "R3";
        if (eff > gd || t > cur) return "R6";
        if (c == 0) return "R9";
        if (cf == 0 && t < cur) return "R7";
        return "R8";
    endfunction

    initial begin
        int f, ss, np, cp, ef, ess, enp;
        int hf, hss, hnp;
        string tag;

        do_reset();
        @(negedge clk);
        // R1
        check(cur_pl == 2'd3, "R1 cur_pl", int'(cur_pl), 3);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);

        // R2 back-pressure: verdict held, new request ignored
        do_reset();
        @(negedge clk);
        in_valid = 1'b1; in_gate = 1'b1; in_call = 1'b1; in_rpl = 2'd3;
        in_tgt_dpl = 2'd1; in_tgt_conf = 1'b0; in_gate_dpl = 2'd3;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        hf = int'(out_fault); hss = int'(out_stack_switch); hnp = int'(out_new_pl);
        check(hf == 0 && hss == 1 && hnp == 1, "R7 held base", hnp, 1);
        in_valid = 1'b1; in_gate = 1'b0; in_tgt_dpl = 2'd0; in_tgt_conf = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(out_valid == 1'b1, "R2 hold valid", int'(out_valid), 1);
            check(in_ready == 1'b0, "R2 hold ready", int'(in_ready), 0);
            check(int'(out_new_pl) == hnp && int'(out_stack_switch) == hss
                  && int'(out_fault) == hf, "R2 hold fields", int'(out_new_pl), hnp);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        check(cur_pl == 2'd1, "R2 ignored request", int'(cur_pl), 1);

        // exhaustive sweep per current level
        for (int cur = 0; cur < 4; cur++)
        for (int g = 0; g < 2; g++)
        for (int c = 0; c < 2; c++)
        for (int cf = 0; cf < 2; cf++)
        for (int r = 0; r < 4; r++)
        for (int t = 0; t < 4; t++)
        for (int gd = 0; gd < 4; gd++) begin
            do_reset();
            if (cur < 3) do_xfer(1, 1, 3, cur, 0, 3, f, ss, np, cp);
            model(cur, g, c, r, t, cf, gd, ef, ess, enp);
            tag = rule_tag(cur, g, c, r, t, cf, gd);
            do_xfer(g, c, r, t, cf, gd, f, ss, np, cp);
            check(f == ef, {tag, " fault"}, f, ef);
            if (ef == 1) begin
                check(ss == 0 && np == cur, "R11 fault outputs", np, cur);
            end else if (g == 0) begin
                check(ss == 0 && np == cur, "R5 direct keeps level", np, cur);
            end else begin
                check(ss == ess && np == enp, {tag, " level/switch"}, np * 2 + ss, enp * 2 + ess);
            end
            check(cp == enp, "R10 cur_pl", cp, enp);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule